// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block sits between a memory access controller and a pseudo-static RAM. It drives the memory's active-low power-down pin and gates the controller's chip select. After reset it keeps the memory in standby, with chip select and power-down both high, for the full power-up interval. Only then does it raise `acc_ready`, which tells the access controller it may start cycles.

The host can ask the memory to sleep. The request is taken only while the access controller reports that it is idle. The sequencer then drops `acc_ready` and forces chip select high for one cycle. After that it pulls the power-down pin low. The pin stays low for at least the minimum low time. A wake request that arrives earlier is remembered and acted on when that time has passed. Once the pin is released, the sequencer waits out the wake-up interval before it grants accesses again.

A deep power-down loses the array contents, so the block raises a `data_lost` flag each time it enters power-down. Only the host clears this flag. All intervals are given in nanoseconds and converted to clock cycles by rounding up.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `acc_ready` is 0, `mem_cs_n` is 1, `mem_pd_n` is 1 and `data_lost` is 1.
- R2: After reset is released, `acc_ready` stays 0 for exactly PWRUP cycles (PWRUP_NS / CLK_PERIOD_NS, rounded up) and then rises. `mem_pd_n` stays 1 throughout.
- R3: `mem_cs_n` equals `acc_cs_n` while `acc_ready` is 1, and is 1 at all other times.
- R4: A sleep request is accepted only when the block is ready and `ctrl_idle` is 1. In the cycle it is accepted, `acc_ready` is already 0.
- R5: After acceptance there is one cycle with `mem_cs_n` and `mem_pd_n` both 1, and then `mem_pd_n` goes low. While `mem_pd_n` is 0, `mem_cs_n` is 1.
- R6: `mem_pd_n` stays 0 for at least MINLOW cycles. A `wake_req` pulse seen earlier in the power-down sequence is held, and `mem_pd_n` returns to 1 right after MINLOW cycles.
- R7: Without a wake request, `mem_pd_n` stays 0 indefinitely.
- R8: After `mem_pd_n` returns to 1, `acc_ready` stays 0 for exactly WAKE cycles.
- R9: `data_lost` is set in the first cycle of every power-down and otherwise changes only when `inval_clr` clears it. A clear in the entry cycle loses to the set.
- R10: `sleep_req` has no effect outside the ready state, and `wake_req` has no effect while the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Host request to enter deep power-down |
| wake_req | input | 1 | Host request to leave deep power-down |
| ctrl_idle | input | 1 | Access controller has no cycle in flight |
| inval_clr | input | 1 | Host clears the contents-lost flag |
| acc_cs_n | input | 1 | Chip select requested by the access controller |
| acc_ready | output | 1 | Accesses may be issued |
| mem_cs_n | output | 1 | Chip select to the memory |
| mem_pd_n | output | 1 | Power-down pin to the memory, low means deep power-down |
| data_lost | output | 1 | Memory contents are invalid |

## Verification
The bench counts cycles exactly at each interval boundary: the power-up release, the minimum low time and the wake-up wait. A design that is off by one in any of these grants or releases one cycle early or late, and the bench reports the edge that moved.

It sends a wake pulse long before the minimum low time expires. A design that does not latch the pulse stays asleep forever, and one that acts on it at once shortens the low time. It also sends sleep while the controller is busy, and a clear in the same cycle as the flag set. Getting either wrong shows up as a premature power-down or as a `data_lost` flag that reads 0 after a power-down.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

   typedef enum logic [2:0] {
      PS_PWRUP = 3'd0,
      PS_READY = 3'd1,
      PS_ENTER = 3'd2,
      PS_DOWN  = 3'd3,
      PS_WAKE  = 3'd4
   } psq_state_t;

   // Interval in ns to clock cycles, rounded up, never below one.
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] limit,
   output logic         done
);
   logic [W-1:0] cnt;

   assign done = ({1'b0, cnt} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (!done)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
   import psram_pwr_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter int unsigned PWRUP_CYC  = 10,
   parameter int unsigned MINLOW_CYC = 5,
   parameter int unsigned WAKE_CYC   = 8,
   parameter bit          HOLD_WAKE  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sleep_req,
   input  logic         wake_req,
   input  logic         ctrl_idle,
   input  logic         tmr_done,
   output psq_state_t   state,
   output logic         accept,
   output logic         restart,
   output logic [W-1:0] limit
);
   psq_state_t nxt;
   logic       go_wake;

   assign accept = (state == PS_READY) && sleep_req && ctrl_idle;

   generate
      if (HOLD_WAKE) begin : g_hold
         logic pend;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend <= 1'b0;
            else if (state == PS_ENTER || state == PS_DOWN)
               pend <= pend | wake_req;
            else
               pend <= 1'b0;
         end
         assign go_wake = tmr_done && (pend || wake_req);
      end else begin : g_level
         assign go_wake = tmr_done && wake_req;
      end
   endgenerate

   always_comb begin
      nxt = state;
      unique case (state)
         PS_PWRUP: if (tmr_done) nxt = PS_READY;
         PS_READY: if (accept)   nxt = PS_ENTER;
         PS_ENTER: nxt = PS_DOWN;
         PS_DOWN:  if (go_wake)  nxt = PS_WAKE;
         PS_WAKE:  if (tmr_done) nxt = PS_READY;
         default:  nxt = PS_PWRUP;
      endcase
   end

   always_comb begin
      unique case (state)
         PS_PWRUP: limit = W'(PWRUP_CYC);
         PS_DOWN:  limit = W'(MINLOW_CYC);
         PS_WAKE:  limit = W'(WAKE_CYC);
         default:  limit = W'(1);
      endcase
   end

   assign restart = (nxt != state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_PWRUP;
      else        state <= nxt;
   end
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
   import psram_pwr_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS   = 20,
   parameter int unsigned PWRUP_NS        = 100000,
   parameter int unsigned MINLOW_NS       = 1000,
   parameter int unsigned WAKE_NS         = 100000,
   parameter bit          HOLD_EARLY_WAKE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_req,
   input  logic ctrl_idle,
   input  logic inval_clr,
   input  logic acc_cs_n,
   output logic acc_ready,
   output logic mem_cs_n,
   output logic mem_pd_n,
   output logic data_lost
);
   localparam int unsigned PWRUP_CYC  = ns2cyc(PWRUP_NS, CLK_PERIOD_NS);
   localparam int unsigned MINLOW_CYC = ns2cyc(MINLOW_NS, CLK_PERIOD_NS);
   localparam int unsigned WAKE_CYC   = ns2cyc(WAKE_NS, CLK_PERIOD_NS);
   localparam int unsigned MAX_A      = (PWRUP_CYC > WAKE_CYC) ? PWRUP_CYC : WAKE_CYC;
   localparam int unsigned MAX_CYC    = (MAX_A > MINLOW_CYC) ? MAX_A : MINLOW_CYC;
   localparam int unsigned W          = $clog2(MAX_CYC + 1);

   initial begin
      if (CLK_PERIOD_NS == 0) $error("psram_pwr_seq: clock period must be nonzero");
   end

   psq_state_t   state;
   logic         accept, restart, tmr_done;
   logic [W-1:0] limit;

   psq_fsm #(
      .W(W), .PWRUP_CYC(PWRUP_CYC), .MINLOW_CYC(MINLOW_CYC),
      .WAKE_CYC(WAKE_CYC), .HOLD_WAKE(HOLD_EARLY_WAKE)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .ctrl_idle(ctrl_idle), .tmr_done(tmr_done), .state(state),
      .accept(accept), .restart(restart), .limit(limit)
   );

   psq_timer #(.W(W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(restart), .limit(limit), .done(tmr_done)
   );

   assign acc_ready = (state == PS_READY) && !accept;
   assign mem_cs_n  = acc_cs_n | ~acc_ready;
   assign mem_pd_n  = (state != PS_DOWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 data_lost <= 1'b1;
      else if (state == PS_ENTER) data_lost <= 1'b1;
      else if (inval_clr)         data_lost <= 1'b0;
   end
endmodule

// File: rtl/psram_pwr_chk.sv
module psram_pwr_chk #(
   parameter int unsigned MINLOW_CYC = 5,
   parameter int unsigned WAKE_CYC   = 8,
   parameter int unsigned PWRUP_CYC  = 10
) (
   input logic clk,
   input logic rst_n,
   input logic inval_clr,
   input logic acc_cs_n,
   input logic acc_ready,
   input logic mem_cs_n,
   input logic mem_pd_n,
   input logic data_lost
);
   localparam int unsigned UP_MIN = (WAKE_CYC < PWRUP_CYC) ? WAKE_CYC : PWRUP_CYC;

   int unsigned low_cnt, up_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= 0;
         up_cnt  <= 0;
      end else begin
         low_cnt <= mem_pd_n ? 0 : low_cnt + 1;
         up_cnt  <= !mem_pd_n ? 0 : (up_cnt < UP_MIN ? up_cnt + 1 : up_cnt);
      end
   end

   AST_PD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_pd_n |-> mem_cs_n); // R5
   AST_PD_ENTRY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_pd_n) |-> $past(mem_cs_n) && !$past(acc_ready)); // R5
   AST_CS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ready |-> mem_cs_n == acc_cs_n); // R3
   AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_pd_n) |-> low_cnt >= MINLOW_CYC); // R6
   AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_ready) |-> up_cnt >= UP_MIN); // R8
   AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ready |-> mem_pd_n); // R8
   AST_LOST_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_pd_n) |-> data_lost); // R9
   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      data_lost && !inval_clr |=> data_lost); // R9
   AST_LOST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_lost) |-> $fell(mem_pd_n)); // R9
endmodule

bind psram_pwr_seq psram_pwr_chk #(
   .MINLOW_CYC(MINLOW_CYC), .WAKE_CYC(WAKE_CYC), .PWRUP_CYC(PWRUP_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .inval_clr(inval_clr), .acc_cs_n(acc_cs_n),
   .acc_ready(acc_ready), .mem_cs_n(mem_cs_n), .mem_pd_n(mem_pd_n),
   .data_lost(data_lost)
);

// File: tb/tb_psram_pwr_seq.sv
module tb_psram_pwr_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b0, inval_clr = 1'b0, acc_cs_n = 1'b1;
   logic acc_ready, mem_cs_n, mem_pd_n, data_lost;

   int n_run = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   // 20 ns clock: power-up 10 cycles, minimum low 5 cycles, wake 8 cycles
   psram_pwr_seq #(
      .CLK_PERIOD_NS(20), .PWRUP_NS(200), .MINLOW_NS(100), .WAKE_NS(160),
      .HOLD_EARLY_WAKE(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .ctrl_idle(ctrl_idle), .inval_clr(inval_clr), .acc_cs_n(acc_cs_n),
      .acc_ready(acc_ready), .mem_cs_n(mem_cs_n), .mem_pd_n(mem_pd_n),
      .data_lost(data_lost)
   );

   // {sleep, wake, idle, clr, acc_cs_n | ready, cs_n, pd_n, lost}
   localparam logic [8:0] VEC [19] = '{
      9'b01100_1010, // ready; wake ignored (R10)
      9'b10000_1010, // sleep while busy: refused (R4)
      9'b10100_0110, // accepted, ready drops at once (R4)
      9'b00100_0110, // guard cycle (R5)
      9'b01100_0101, // power-down, early wake (R6, R9)
      9'b00100_0101,
      9'b00100_0101,
      9'b00100_0101,
      9'b00100_0101, // last low cycle (R6)
      9'b10100_0111, // wake wait, sleep ignored (R10, R8)
      9'b00100_0111,
      9'b00100_0111,
      9'b00100_0111,
      9'b00100_0111,
      9'b00100_0111,
      9'b00100_0111,
      9'b00100_0111, // last wake cycle (R8)
      9'b00110_1011, // ready again, clear flag (R3, R9)
      9'b00101_1110  // follows acc_cs_n (R3, R9)
   };

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #2;
      chk("R1", "ready", acc_ready, 1'b0);
      chk("R1", "cs_n", mem_cs_n, 1'b1);
      chk("R1", "pd_n", mem_pd_n, 1'b1);
      chk("R1", "lost", data_lost, 1'b1);

      // R2: power-up hold, sleep during it ignored (R10)
      @(negedge clk);
      rst_n = 1'b1; sleep_req = 1'b1; ctrl_idle = 1'b1; acc_cs_n = 1'b0;
      for (int k = 1; k <= 9; k++) begin
         @(negedge clk);
         if (k == 5) sleep_req = 1'b0;
         #2;
         chk("R2", "ready during power-up", acc_ready, 1'b0);
         chk("R2", "pd_n during power-up", mem_pd_n, 1'b1);
         chk("R3", "cs_n gated", mem_cs_n, 1'b1);
      end
      @(negedge clk); #2;
      chk("R2", "ready after power-up", acc_ready, 1'b1);
      chk("R10", "sleep in power-up ignored", mem_pd_n, 1'b1);

      // R9: clear flag
      inval_clr = 1'b1;
      @(negedge clk); inval_clr = 1'b0; #2;
      chk("R9", "lost cleared", data_lost, 1'b0);

      // Table walk
      for (int i = 0; i < 19; i++) begin
         @(negedge clk);
         {sleep_req, wake_req, ctrl_idle, inval_clr, acc_cs_n} = VEC[i][8:4];
         #2;
         chk("R3-R10 table", "ready", acc_ready, VEC[i][3]);
         chk("R3-R10 table", "cs_n", mem_cs_n, VEC[i][2]);
         chk("R3-R10 table", "pd_n", mem_pd_n, VEC[i][1]);
         chk("R3-R10 table", "lost", data_lost, VEC[i][0]);
      end

      // Late wake; clear in entry cycle loses to set
      @(negedge clk);
      sleep_req = 1'b1; ctrl_idle = 1'b1; inval_clr = 1'b0; acc_cs_n = 1'b0;
      @(negedge clk);
      sleep_req = 1'b0; inval_clr = 1'b1; #2;
      chk("R5", "guard pd_n", mem_pd_n, 1'b1);
      @(negedge clk);
      inval_clr = 1'b0; #2;
      chk("R9", "set beats clear", data_lost, 1'b1);
      chk("R5", "pd_n low", mem_pd_n, 1'b0);
      chk("R5", "cs_n high in power-down", mem_cs_n, 1'b1);
      repeat (20) @(negedge clk);
      #2;
      chk("R7", "stays down without wake", mem_pd_n, 1'b0);
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0; #2;
      chk("R6", "late wake releases pin", mem_pd_n, 1'b1);
      chk("R8", "not ready at wake start", acc_ready, 1'b0);
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk); #2;
         chk("R8", "not ready in wake wait", acc_ready, 1'b0);
      end
      @(negedge clk); #2;
      chk("R8", "ready after wake wait", acc_ready, 1'b1);
      chk("R3", "cs_n follows", mem_cs_n, 1'b0);
      chk("R9", "lost held", data_lost, 1'b1);

      summary();
   end
endmodule